// File: doc/BRIEF.md
# Truncating Single-Precision Multiply/Divide Unit

This unit takes two single-precision floating-point operands and either multiplies or divides them. The choice is made by one select line, sampled together with the operands on a start pulse. The operands are normal numbers or zero. The 32-bit result keeps the usual field layout: sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0. The result is rounded toward zero, so every significand bit below the 23-bit fraction is dropped.

A multiply adds the exponents and forms the full 48-bit product of the two 24-bit significands, hidden one included. If the product is two or more, the unit shifts it right by one and raises the exponent by one. A divide subtracts the exponents and runs an iterative restoring divide. This divide is equivalent to an integer divide of the dividend significand, extended with `QFRAC` zero bits, by the divisor significand, and it produces one quotient bit per cycle. A quotient below one is shifted left once and the exponent is lowered by one. At the end, an out-of-range exponent is saturated to infinity or flushed to zero.

The result and the divide-by-zero flag are registered. They hold until the next operation completes, and `done` pulses for one cycle when they update.

Top module: `fpmd_unit`

## Requirements
- R1: The result sign (bit 31) is the XOR of the two operand sign bits, for every result including zeros and infinities.
- R2: Multiply: the biased exponent is ea + eb - 127. When the 48-bit significand product has its bit 47 set (value two or more), the product is shifted right by one and the exponent is incremented.
- R3: Divide: the biased exponent is ea - eb + 127. When the significand quotient is below one, it is shifted left once and the exponent is decremented.
- R4: Significand bits below the 23-bit fraction are truncated, never rounded. For example, 1.0/3.0 gives 0x3EAAAAAA.
- R5: The divide quotient is floor((ma << QFRAC) / mb), with ma and mb the 24-bit significands including the hidden one, so it carries QFRAC fractional bits. QFRAC defaults to 24.
- R6: A multiply with either operand zero (exponent field 0) gives a signed zero. A divide of zero by a non-zero divisor gives a signed zero.
- R7: A divide by a zero divisor gives a signed infinity (exponent 0xFF, fraction 0) and raises `div_by_zero`. `div_by_zero` is 0 for every other result.
- R8: A final biased exponent of 255 or more gives a signed infinity.
- R9: A final biased exponent of 0 or less gives a signed zero.
- R10: `done` is a one-cycle pulse. It rises 1 cycle after the start edge for a multiply and QFRAC+2 cycles after it for a divide. `busy` is high from the cycle after the start edge up to, but not including, the `done` cycle.
- R11: A `start` raised while `busy` is high is ignored. The running operation still returns the result of its original operands, and no second operation follows.
- R12: After reset, `busy`, `done`, `result` and `div_by_zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| op_div | input | 1 | 1 = divide a by b, 0 = multiply |
| a | input | 32 | First operand (dividend) |
| b | input | 32 | Second operand (divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when result updates |
| result | output | 32 | Truncated single-precision result |
| div_by_zero | output | 1 | Result came from a zero divisor |

## Verification
The assertions take for granted that every operand has an exponent field between 1 and 254 or equal to 0 with a zero fraction. Under that assumption, the dividend significand is always below twice the divisor significand, and a non-degenerate quotient always has one of its two top bits set. The stimulus keeps within this. Random operands draw exponent fields from 64 to 191, and every directed case uses hand-picked normal values or exact zeros, with the exponents of the overflow and underflow cases chosen to land exactly on and just past the limits.

// File: rtl/fpmd_pkg.sv
package fpmd_pkg;

  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = 127;

  // Repack a sign, a wide signed biased exponent and a fraction,
  // saturating to infinity or flushing to zero at the range ends.
  function automatic logic [31:0] pack_sat(input logic s,
                                           input logic signed [11:0] e,
                                           input logic [FRAC_W-1:0] f);
    if (e >= 12'sd255)
      return {s, 8'hFF, {FRAC_W{1'b0}}};
    else if (e <= 12'sd0)
      return {s, 31'b0};
    else
      return {s, e[EXP_W-1:0], f};
  endfunction

  function automatic logic [31:0] signed_zero(input logic s);
    return {s, 31'b0};
  endfunction

  function automatic logic [31:0] signed_inf(input logic s);
    return {s, 8'hFF, {FRAC_W{1'b0}}};
  endfunction

endpackage

// File: rtl/fpmd_sigdiv.sv
module fpmd_sigdiv #(
  parameter int QFRAC = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [23:0]      dividend,
  input  logic [23:0]      divisor,
  output logic [QFRAC:0]   quot,
  output logic             last
);
  localparam int CW = $clog2(QFRAC + 1);

  logic [24:0]   rem;
  logic [23:0]   dvsr;
  logic [CW-1:0] cnt;
  logic          act;
  logic          qbit;
  logic [24:0]   rem_sub;

  assign qbit    = (rem >= {1'b0, dvsr});
  assign rem_sub = qbit ? (rem - {1'b0, dvsr}) : rem;
  assign last    = act && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      dvsr <= '0;
      cnt  <= '0;
      act  <= 1'b0;
      quot <= '0;
    end else if (load) begin
      rem  <= {1'b0, dividend};
      dvsr <= divisor;
      cnt  <= CW'(QFRAC);
      act  <= 1'b1;
      quot <= '0;
    end else if (act) begin
      quot <= {quot[QFRAC-1:0], qbit};
      rem  <= {rem_sub[23:0], 1'b0};
      if (cnt == '0) act <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  // R5: the partial remainder stays below twice the divisor, so each step yields one bit
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && dvsr != '0) |-> (rem < {dvsr, 1'b0}));

endmodule

// File: rtl/fpmd_pack.sv
module fpmd_pack
  import fpmd_pkg::*;
#(
  parameter int QFRAC = 24
) (
  input  logic               is_div,
  input  logic               sign,
  input  logic [7:0]         ea,
  input  logic [7:0]         eb,
  input  logic [23:0]        ma,
  input  logic [23:0]        mb,
  input  logic [QFRAC:0]     quot,
  input  logic               a_zero,
  input  logic               b_zero,
  output logic [31:0]        word,
  output logic               dz
);
  logic [47:0]        prod;
  logic               mul_hi;
  logic [22:0]        mul_frac;
  logic signed [11:0] mul_exp;
  logic               q_low;
  logic [QFRAC:0]     qn;
  logic [22:0]        div_frac;
  logic signed [11:0] div_exp;

  assign prod     = {24'b0, ma} * {24'b0, mb};
  assign mul_hi   = prod[47];
  assign mul_frac = mul_hi ? prod[46:24] : prod[45:23];
  assign mul_exp  = $signed({4'b0, ea}) + $signed({4'b0, eb}) - 12'sd127
                    + $signed({11'b0, mul_hi});

  assign q_low   = !quot[QFRAC];
  assign qn      = q_low ? {quot[QFRAC-1:0], 1'b0} : quot;
  assign div_exp = $signed({4'b0, ea}) - $signed({4'b0, eb}) + 12'sd127
                   - $signed({11'b0, q_low});

  generate
    if (QFRAC >= 23) begin : g_wide
      assign div_frac = qn[QFRAC-1 -: 23];
    end else begin : g_narrow
      assign div_frac = {qn[QFRAC-1:0], {(23-QFRAC){1'b0}}};
    end
  endgenerate

  always_comb begin
    dz = 1'b0;
    if (is_div) begin
      if (b_zero) begin
        word = signed_inf(sign);
        dz   = 1'b1;
      end else if (a_zero) begin
        word = signed_zero(sign);
      end else begin
        word = pack_sat(sign, div_exp, div_frac);
      end
    end else if (a_zero || b_zero) begin
      word = signed_zero(sign);
    end else begin
      word = pack_sat(sign, mul_exp, mul_frac);
    end
  end

endmodule

// File: rtl/fpmd_unit.sv
module fpmd_unit #(
  parameter int QFRAC = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_div,
  input  logic [31:0] a,
  input  logic [31:0] b,
  output logic        busy,
  output logic        done,
  output logic [31:0] result,
  output logic        div_by_zero
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_PACK} state_t;

  state_t         state;
  logic           sign_q, div_q, az_q, bz_q;
  logic [7:0]     ea_q, eb_q;
  logic [22:0]    fa_q, fb_q;
  logic           accept;
  logic           dv_load, dv_last;
  logic [QFRAC:0] quot;
  logic [31:0]    pk_word;
  logic           pk_dz;

  assign busy    = (state != S_IDLE);
  assign accept  = (state == S_IDLE) && start;
  assign dv_load = accept && op_div;

  fpmd_sigdiv #(.QFRAC(QFRAC)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dv_load),
    .dividend ({1'b1, a[22:0]}),
    .divisor  ({(b[30:23] != 8'h00), b[22:0]}),
    .quot     (quot),
    .last     (dv_last)
  );

  fpmd_pack #(.QFRAC(QFRAC)) u_pack (
    .is_div (div_q),
    .sign   (sign_q),
    .ea     (ea_q),
    .eb     (eb_q),
    .ma     ({1'b1, fa_q}),
    .mb     ({1'b1, fb_q}),
    .quot   (quot),
    .a_zero (az_q),
    .b_zero (bz_q),
    .word   (pk_word),
    .dz     (pk_dz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      sign_q      <= 1'b0;
      div_q       <= 1'b0;
      az_q        <= 1'b0;
      bz_q        <= 1'b0;
      ea_q        <= '0;
      eb_q        <= '0;
      fa_q        <= '0;
      fb_q        <= '0;
      done        <= 1'b0;
      result      <= '0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          sign_q <= a[31] ^ b[31];
          div_q  <= op_div;
          ea_q   <= a[30:23];
          eb_q   <= b[30:23];
          fa_q   <= a[22:0];
          fb_q   <= b[22:0];
          az_q   <= (a[30:23] == 8'h00);
          bz_q   <= (b[30:23] == 8'h00);
          state  <= S_RUN;
        end
        S_RUN: if (!div_q) begin
          result      <= pk_word;
          div_by_zero <= pk_dz;
          done        <= 1'b1;
          state       <= S_IDLE;
        end else if (dv_last) begin
          state <= S_PACK;
        end
        default: begin
          result      <= pk_word;
          div_by_zero <= pk_dz;
          done        <= 1'b1;
          state       <= S_IDLE;
        end
      endcase
    end
  end

  // R1
  sign_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (sign_q == ($past(a[31]) ^ $past(b[31]))));

  // R1
  result_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result[31] == sign_q));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(ea_q) && $stable(eb_q) && $stable(div_q)));

  // R3
  quot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PACK && !az_q && !bz_q) |-> (quot[QFRAC] || quot[QFRAC-1]));

  // R7
  dz_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |-> (result[30:0] == 31'h7F800000));

  // R8
  inf_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[30:23] == 8'hFF) |-> (result[22:0] == 23'h0));

  // R9
  zero_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[30:23] == 8'h00) |-> (result[22:0] == 23'h0));

endmodule

// File: tb/tb_fpmd_unit.sv
module tb_fpmd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int QF = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_div = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done, div_by_zero;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  fpmd_unit #(.QFRAC(QF)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .a(a), .b(b), .busy(busy), .done(done), .result(result),
    .div_by_zero(div_by_zero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference built from the requirements with integer arithmetic.
  function automatic logic [31:0] model(input bit dv, input logic [31:0] x,
                                        input logic [31:0] y, output bit dz);
    bit     s = x[31] ^ y[31];
    int     ex = int'(x[30:23]);
    int     ey = int'(y[30:23]);
    longint mx = longint'({1'b1, x[22:0]});
    longint my = longint'({1'b1, y[22:0]});
    longint frac;
    int     e;
    dz = 0;
    if (dv) begin
      if (ey == 0) begin dz = 1; return {s, 8'hFF, 23'h0}; end
      if (ex == 0) return {s, 31'h0};
      frac = (mx <<< QF) / my;
      e = ex - ey + 127;
      if (frac < (longint'(1) <<< QF)) begin frac = frac <<< 1; e = e - 1; end
      if (QF >= 23) frac = (frac >>> (QF - 23)) & 64'h7FFFFF;
      else          frac = (frac <<< (23 - QF)) & 64'h7FFFFF;
    end else begin
      if (ex == 0 || ey == 0) return {s, 31'h0};
      frac = mx * my;
      e = ex + ey - 127;
      if (frac >= (longint'(1) <<< 47)) begin frac = (frac >>> 24) & 64'h7FFFFF; e = e + 1; end
      else frac = (frac >>> 23) & 64'h7FFFFF;
    end
    if (e >= 255) return {s, 8'hFF, 23'h0};
    if (e <= 0)   return {s, 31'h0};
    return {s, e[7:0], frac[22:0]};
  endfunction

  function automatic logic [31:0] step(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  // Launch one operation and follow it every clock against the expected timeline.
  task automatic run_op(input bit dv, input logic [31:0] x, input logic [31:0] y,
                        input string req, input bit poke);
    logic [31:0] exp_r;
    bit exp_dz;
    int lat = dv ? QF + 2 : 1;
    int cyc = 0;
    exp_r = model(dv, x, y, exp_dz);
    @(negedge clk);
    op_div = dv; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < lat + 8) begin
      check(busy === 1'b1, "R10", "busy while running", {31'b0, busy}, 32'h1);
      if (poke && cyc == 1) begin
        start = 1'b1; op_div = ~dv; a = ~x; b = y ^ 32'h4000_0000;
      end
      if (poke && cyc == 2) start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    check(cyc == lat, "R10", "done latency", cyc, lat);
    check(busy === 1'b0, "R10", "busy low at done", {31'b0, busy}, 32'h0);
    check(result === exp_r, req, "result", result, exp_r);
    check(div_by_zero === exp_dz, "R7", "div_by_zero flag", {31'b0, div_by_zero}, {31'b0, exp_dz});
    @(negedge clk);
    check(done === 1'b0, "R10", "done one cycle", {31'b0, done}, 32'h0);
    if (poke) begin
      check(busy === 1'b0, "R11", "no second op after ignored start", {31'b0, busy}, 32'h0);
      check(result === exp_r, "R11", "result kept original operands", result, exp_r);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(busy === 1'b0 && done === 1'b0, "R12", "busy/done in reset", {30'b0, busy, done}, 32'h0);
    check(result === 32'h0 && div_by_zero === 1'b0, "R12", "result in reset", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R12", "idle after reset", {31'b0, busy}, 32'h0);

    // R2 plain multiply and product >= 2
    run_op(0, 32'h4000_0000, 32'h4040_0000, "R2", 0);
    check(result === 32'h40C0_0000, "R2", "2*3 literal", result, 32'h40C0_0000);
    run_op(0, 32'h3FC0_0000, 32'h3FC0_0000, "R2", 0);
    check(result === 32'h4010_0000, "R2", "1.5*1.5 literal", result, 32'h4010_0000);
    // R1 sign combinations
    run_op(0, 32'hC0B8_0000, 32'h42FA_8000, "R1", 0);
    run_op(1, 32'hC0C0_0000, 32'hC040_0000, "R1", 0);
    check(result === 32'h4000_0000, "R1", "-6/-3 literal", result, 32'h4000_0000);
    // R3 quotient below one, R4 truncation
    run_op(1, 32'h3F80_0000, 32'h3FC0_0000, "R3", 0);
    check(result === 32'h3F2A_AAAA, "R3", "1/1.5 literal", result, 32'h3F2A_AAAA);
    run_op(1, 32'h3F80_0000, 32'h4040_0000, "R4", 0);
    check(result === 32'h3EAA_AAAA, "R4", "1/3 truncated", result, 32'h3EAA_AAAA);
    // R5 quotient bits
    run_op(1, 32'h7B39_0000, 32'hC8C0_0000, "R5", 0);
    run_op(1, 32'h3FFF_FFFF, 32'h3F80_0001, "R5", 0);
    // R6 zeros
    run_op(0, 32'h0000_0000, 32'hC000_0000, "R6", 0);
    check(result === 32'h8000_0000, "R6", "0*-2 literal", result, 32'h8000_0000);
    run_op(0, 32'h4100_0000, 32'h8000_0000, "R6", 0);
    run_op(1, 32'h0000_0000, 32'h4000_0000, "R6", 0);
    // R7 divide by zero
    run_op(1, 32'h3F80_0000, 32'h0000_0000, "R7", 0);
    check(result === 32'h7F80_0000 && div_by_zero === 1'b1, "R7", "1/0 literal", result, 32'h7F80_0000);
    run_op(1, 32'hC2FA_8000, 32'h8000_0000, "R7", 0);
    // R8 overflow boundary
    run_op(0, 32'h7E80_0000, 32'h4000_0000, "R8", 0);
    check(result === 32'h7F00_0000, "R8", "exp 254 kept", result, 32'h7F00_0000);
    run_op(0, 32'h7F00_0000, 32'h4080_0000, "R8", 0);
    check(result === 32'h7F80_0000, "R8", "exp 256 saturates", result, 32'h7F80_0000);
    run_op(1, 32'h7F00_0000, 32'h0080_0000, "R8", 0);
    // R9 underflow boundary
    run_op(0, 32'h0080_0000, 32'h3F00_0000, "R9", 0);
    check(result === 32'h0000_0000, "R9", "exp 0 flushes", result, 32'h0);
    run_op(0, 32'h0100_0000, 32'h3F00_0000, "R9", 0);
    check(result === 32'h0080_0000, "R9", "exp 1 kept", result, 32'h0080_0000);
    run_op(1, 32'h8080_0000, 32'h4000_0000, "R9", 0);
    // R11 start while busy
    run_op(1, 32'h40B8_0000, 32'h42FA_8000, "R11", 1);
    run_op(1, 32'hBF80_0000, 32'h4040_0000, "R11", 1);

    for (int i = 0; i < 60; i++) begin
      logic [31:0] x, y;
      lfsr = step(lfsr); x = lfsr;
      lfsr = step(lfsr); y = lfsr;
      x[30:23] = 8'd64 + {1'b0, x[29:23]};
      y[30:23] = 8'd64 + {1'b0, y[29:23]};
      run_op(i[0], x, y, i[0] ? "R3" : "R2", 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule